// File: doc/BRIEF.md
# Partitioned SIMD Equality Comparator

This block compares two wide operands for equality, where the operand word can be split at run time into independent lanes. The word is cut into four equal segments, numbered 0 to 3 from the least significant end. A 3-bit partition control decides where lane boundaries fall: bit i of the control, when set, separates segment i from segment i+1. Each segment pair is compared on its own, and the segment results are then combined by AND within every lane.

The result is a 4-bit vector with one bit per segment slot. A lane reports its equality flag in the slot of its lowest segment. Every slot that does not start a lane is forced to zero. Slot 0 always starts a lane, so it is never forced to zero by the partition setting. With no control bits set, the whole word is a single lane. With all three set, each segment is a lane of its own.

By default a clocked output register holds the result. It is cleared by an active-low asynchronous reset. A parameter can remove the register, and the block is then purely combinational.

Top module: `simd_part_eq`

## Requirements
- R1: With the output register present, eq_o is 4'b0000 while rst_ni is low.
- R2: With part_i = 3'b000, eq_o[0] is 1 exactly when all four segments match, and eq_o[3:1] is 0.
- R3: With part_i = 3'b111, eq_o[i] is 1 exactly when segment i of a_i equals segment i of b_i, for i = 0 to 3.
- R4: For any part_i, a slot i that starts a lane (i = 0, or part_i[i-1] = 1) carries the AND of the segment matches from segment i up to the next boundary. Examples: for part_i = 3'b010, eq_o[0] is the AND of matches 0 and 1, and eq_o[2] is the AND of matches 2 and 3. For part_i = 3'b101, eq_o = {m3, 1'b0, m1&m2, m0}.
- R5: A slot i >= 1 with part_i[i-1] = 0 reads 0 whatever the operands are. Example: for part_i = 3'b100, eq_o[2:1] = 0, eq_o[0] = m0&m1&m2 and eq_o[3] = m3.
- R6: eq_o[0] is never masked. When a_i equals b_i, eq_o equals {part_i, 1'b1}.
- R7: With the output register present (REG_OUT = 1), eq_o shows the result for the inputs sampled at the previous rising edge of clk_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| a_i | input | 4*SEG_W | First operand |
| b_i | input | 4*SEG_W | Second operand |
| part_i | input | 3 | Lane boundary control; bit i splits segment i from segment i+1 |
| eq_o | output | 4 | Equality flag per lane, placed at the lane's lowest slot |

## Verification
A fault in the segment compares or in the merge shows up in eq_o one edge after the operands are applied, or at once without the register. It appears as a lane flag that ignores a mismatched segment, a slot set that should be masked, or a boundary read from the wrong control bit. Operands are chosen so that only some segments differ, each by a single bit. This way a wrong AND span or a shifted boundary changes the flag in at least one case for each partition setting. A faulty reset or a missing latency stage shows as a nonzero output under reset, or as results that are one vector out of step.

// File: rtl/simd_eq_pkg.sv
package simd_eq_pkg;
  localparam int unsigned NUM_SEG = 4;
  localparam int unsigned PART_W  = NUM_SEG - 1;
  typedef logic [NUM_SEG-1:0] seg_vec_t;
  typedef logic [PART_W-1:0]  part_vec_t;
endpackage

// File: rtl/simd_seg_cmp.sv
module simd_seg_cmp
  import simd_eq_pkg::*;
#(
  parameter int unsigned SEG_W  = 8,
  localparam int unsigned DATA_W = SEG_W * NUM_SEG
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output seg_vec_t          seg_eq_o
);
  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    assign seg_eq_o[s] = (a_i[s*SEG_W +: SEG_W] == b_i[s*SEG_W +: SEG_W]);
  end
endmodule

// File: rtl/simd_lane_merge.sv
module simd_lane_merge
  import simd_eq_pkg::*;
(
  input  seg_vec_t  seg_eq_i,
  input  part_vec_t part_i,
  output seg_vec_t  lane_eq_o
);
  seg_vec_t lead;

  // slot 0 always leads; slot i leads when boundary i-1 is set
  assign lead = {part_i, 1'b1};

  for (genvar i = 0; i < NUM_SEG; i++) begin : g_slot
    logic acc;
    always_comb begin
      logic open;
      open = 1'b1;
      acc  = seg_eq_i[i];
      for (int k = i + 1; k < NUM_SEG; k++) begin
        open = open & ~part_i[k-1];
        if (open) acc = acc & seg_eq_i[k];
      end
    end
    assign lane_eq_o[i] = lead[i] & acc;
  end
endmodule

// File: rtl/simd_out_stage.sv
module simd_out_stage
  import simd_eq_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  seg_vec_t d_i,
  output seg_vec_t q_o
);
  if (REG_OUT) begin : g_reg
    seg_vec_t q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else         q <= d_i;
    end
    assign q_o = q;
  end else begin : g_comb
    assign q_o = d_i;
  end
endmodule

// File: rtl/simd_part_eq.sv
module simd_part_eq
  import simd_eq_pkg::*;
#(
  parameter int unsigned SEG_W   = 8,
  parameter bit          REG_OUT = 1'b1,
  localparam int unsigned DATA_W = SEG_W * NUM_SEG
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [PART_W-1:0] part_i,
  output logic [NUM_SEG-1:0] eq_o
);
  seg_vec_t seg_eq;
  seg_vec_t lane_eq;

  simd_seg_cmp #(.SEG_W(SEG_W)) u_cmp (
    .a_i      (a_i),
    .b_i      (b_i),
    .seg_eq_o (seg_eq)
  );

  simd_lane_merge u_merge (
    .seg_eq_i  (seg_eq),
    .part_i    (part_i),
    .lane_eq_o (lane_eq)
  );

  simd_out_stage #(.REG_OUT(REG_OUT)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (lane_eq),
    .q_o    (eq_o)
  );
endmodule

// File: rtl/simd_part_eq_chk.sv
module simd_part_eq_chk
  import simd_eq_pkg::*;
#(
  parameter int unsigned SEG_W   = 8,
  parameter bit          REG_OUT = 1'b1,
  localparam int unsigned DATA_W = SEG_W * NUM_SEG
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] b_i,
  input logic [PART_W-1:0] part_i,
  input logic [NUM_SEG-1:0] eq_o
);
  logic [DATA_W-1:0] a_s, b_s;
  logic [PART_W-1:0] p_s;
  logic              live;
  seg_vec_t          m_s;

  if (REG_OUT) begin : g_dly
    logic [DATA_W-1:0] a_q, b_q;
    logic [PART_W-1:0] p_q;
    logic              seen_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        a_q <= '0; b_q <= '0; p_q <= '0; seen_q <= 1'b0;
      end else begin
        a_q <= a_i; b_q <= b_i; p_q <= part_i; seen_q <= 1'b1;
      end
    end
    assign a_s = a_q; assign b_s = b_q; assign p_s = p_q; assign live = seen_q;

    // R1
    a_r1_reset_clear: assert property (@(posedge clk_i) !rst_ni |-> eq_o == '0);
  end else begin : g_now
    assign a_s = a_i; assign b_s = b_i; assign p_s = part_i; assign live = 1'b1;
  end

  always_comb
    for (int s = 0; s < NUM_SEG; s++)
      m_s[s] = (a_s[s*SEG_W +: SEG_W] == b_s[s*SEG_W +: SEG_W]);

  a_r2_one_lane: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && p_s == '0) |-> (eq_o == {3'b000, &m_s}));

  a_r3_all_split: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && p_s == '1) |-> (eq_o == m_s));

  // R4: a set flag implies its own segment matched
  a_r4_flag_needs_seg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live |-> ((eq_o & ~m_s) == '0));

  a_r5_masked_slots: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live |-> ((eq_o & ~{p_s, 1'b1}) == '0));

  a_r6_full_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && a_s == b_s) |-> (eq_o == {p_s, 1'b1}));
endmodule

bind simd_part_eq simd_part_eq_chk #(.SEG_W(SEG_W), .REG_OUT(REG_OUT)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .a_i    (a_i),
  .b_i    (b_i),
  .part_i (part_i),
  .eq_o   (eq_o)
);

// File: tb/simd_part_eq_test.sv
module simd_part_eq_test;
  localparam int CLK_PERIOD = 10;
  localparam int SEG_W      = 8;
  localparam int DATA_W     = 4 * SEG_W;
  localparam int VEC_PER_P  = 40;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic [DATA_W-1:0] a = '0, b = '0;
  logic [2:0]        part = '0;
  logic [3:0]        eq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [3:0]  exp_q[$];
  string       tag_q[$];

  simd_part_eq #(.SEG_W(SEG_W), .REG_OUT(1'b1)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .a_i(a), .b_i(b), .part_i(part), .eq_o(eq_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [3:0] ref_eq(logic [DATA_W-1:0] x, logic [DATA_W-1:0] y,
                                        logic [2:0] p);
    logic [3:0] r = '0;
    int lead = 0;
    for (int i = 0; i < 4; i++) begin
      bit m = (x[i*SEG_W +: SEG_W] == y[i*SEG_W +: SEG_W]);
      if (i == 0 || p[i-1]) begin
        lead = i;
        r[lead] = m;
      end else begin
        r[lead] = r[lead] & m;
      end
    end
    return r;
  endfunction

  function automatic string tag_for(logic [2:0] p, bit same);
    if (same)       return "R6 R7";
    if (p == 3'b000) return "R2 R7";
    if (p == 3'b111) return "R3 R7";
    if (p == 3'b100) return "R5 R7";
    return "R4 R7";
  endfunction

  task automatic check(bit ok, string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // compare previous vector, then apply a new one
  task automatic step(logic [DATA_W-1:0] x, logic [DATA_W-1:0] y, logic [2:0] p);
    @(negedge clk);
    if (exp_q.size() > 0) begin
      logic [3:0] e = exp_q.pop_front();
      string t = tag_q.pop_front();
      check(eq_o === e, t, eq_o, e);
    end
    a = x; b = y; part = p;
    exp_q.push_back(ref_eq(x, y, p));
    tag_q.push_back(tag_for(p, x == y));
  endtask

  function automatic logic [DATA_W-1:0] spoil(logic [DATA_W-1:0] x, logic [3:0] mask);
    logic [DATA_W-1:0] r = x;
    for (int s = 0; s < 4; s++)
      if (mask[s]) r[s*SEG_W + ($urandom % SEG_W)] ^= 1'b1;
    return r;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check(eq_o === 4'b0000, "R1", eq_o, 4'b0000);
    rst_ni = 1'b1;

    for (int p = 0; p < 8; p++) begin
      logic [DATA_W-1:0] x;
      x = $urandom;
      step(x, x, 3'(p));
      step(x, ~x, 3'(p));
      for (int s = 0; s < 4; s++) step(x, spoil(x, 4'(1 << s)), 3'(p));
      for (int v = 0; v < VEC_PER_P; v++) begin
        x = $urandom;
        step(x, spoil(x, 4'($urandom)), 3'(p));
      end
    end

    // asynchronous reset in mid-run clears the output at once
    step(32'h5a5a_5a5a, 32'h5a5a_5a5a, 3'b111);
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    check(eq_o === 4'b0000, "R1", eq_o, 4'b0000);
    exp_q.delete();
    tag_q.delete();
    @(negedge clk);
    rst_ni = 1'b1;
    step(32'h1234_5678, 32'h1234_5678, 3'b010);
    step(32'h0, 32'h0, 3'b000);
    step(32'h0, 32'h0, 3'b000);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R7 watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule